// File: doc/BRIEF.md
# Flit Queue with Early Backpressure

This block is a first-in first-out buffer for network flits, intended to sit at the input of every routing and arbitration stage of a packet-switched on-chip network. Storage is a chain of registers: each accepted flit shifts into the first stage, and the oldest flit is read from the stage whose position equals the current occupancy minus one. The chain has no reset and no address decode on the write side, so it maps onto shift-register primitives.

The write side has no ready signal. Instead it drives a single stop bit to the sender. The link between sender and queue may be pipelined, so the sender only sees the stop bit some cycles after it changes. During that time it keeps sending. The queue therefore raises the stop bit while `ROUND_TRIP` free entries still remain, and those entries absorb the flits already on their way. The read side presents the oldest flit with a valid bit and takes a hold bit from downstream. `ROUND_TRIP` must be less than `DEPTH`.

Top module: `sr_flit_queue`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0 and `in_stall` is 0.
- R2: Flits leave in the order they were accepted, with their bits unchanged.
- R3: The sender never writes into a queue that is truly full, unless a read happens in the same cycle. A sender that honours `in_stall` with up to `ROUND_TRIP` cycles of delay never causes such a write.
- R4: `in_stall` is 1 exactly when the number of free entries is at most `ROUND_TRIP`. It reflects the occupancy left by the most recent clock edge.
- R5: A cycle with both a write and a read (`out_valid`=1, `out_stall`=0) leaves the occupancy unchanged: afterwards `out_valid` stays 1 and `in_stall` keeps its value.
- R6: While `out_valid`=1 and `out_stall`=1, the next cycle shows the same `out_valid` and the same `out_data`, even if writes arrive.
- R7: `out_valid` is 1 exactly when the occupancy is nonzero. A flit written into an empty queue is presented one clock edge after the write.
- R8: With reads held off, a sender that reacts to `in_stall` exactly `ROUND_TRIP` cycles late fills the queue to exactly `DEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A flit is offered on `in_data` this cycle |
| in_data | input | DATA_W | Incoming flit |
| in_stall | output | 1 | Stop request to the sender (1 = stop), registered |
| out_valid | output | 1 | `out_data` holds the oldest stored flit |
| out_data | output | DATA_W | Oldest stored flit |
| out_stall | input | 1 | Downstream hold (1 = do not take the flit) |

## Verification
A write changes the queue at the next rising edge. `out_valid`, `in_stall` and the read position are all registers, so every result becomes visible one edge after the write or read that caused it. Inputs are driven just after a rising edge, and outputs are sampled at the falling edge. At that point the bench compares them with an occupancy model that includes every edge so far, and the model is then advanced for the coming edge. The sender model keeps a history of `in_stall` samples and acts on the one from `ROUND_TRIP` cycles earlier. This reproduces the worst-case in-flight window, so the exact-fill and no-overflow checks probe the threshold at its edge.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  // What one clock edge does to the queue occupancy.
  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_INC  = 2'b01,
    OCC_DEC  = 2'b10,
    OCC_SWAP = 2'b11
  } occ_op_e;

  function automatic occ_op_e occ_op(input logic wr, input logic rd);
    return occ_op_e'({rd, wr});
  endfunction

endpackage

// File: rtl/sfq_shift_chain.sv
module sfq_shift_chain #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] taps [DEPTH];

  // One register per stage, no reset, common enable: maps onto shift-register cells.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [DATA_W-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (shift_en) q <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (shift_en) q <= g_stage[i-1].q;
      end
    end
    assign taps[i] = q;
  end

  assign dout = taps[rd_idx];

endmodule

// File: rtl/sfq_occupancy.sv
module sfq_occupancy
  import sfq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int ROUND_TRIP = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  output logic [IDX_W-1:0] rd_idx,
  output logic             not_empty,
  output logic             full,
  output logic             stall
);

  localparam logic [CNT_W-1:0] CAP    = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] MARGIN = CNT_W'(ROUND_TRIP);

  logic [CNT_W-1:0] cnt_q, cnt_n, last_n;

  always_comb begin
    unique case (occ_op(wr, rd))
      OCC_INC: cnt_n = cnt_q + CNT_W'(1);
      OCC_DEC: cnt_n = cnt_q - CNT_W'(1);
      default: cnt_n = cnt_q;
    endcase
    last_n = cnt_n - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rd_idx    <= '0;
      not_empty <= 1'b0;
      full      <= 1'b0;
      stall     <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      rd_idx    <= last_n[IDX_W-1:0];
      not_empty <= (cnt_n != '0);
      full      <= (cnt_n == CAP);
      stall     <= ((CAP - cnt_n) <= MARGIN);
    end
  end

endmodule

// File: rtl/sr_flit_queue.sv
module sr_flit_queue #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  parameter int ROUND_TRIP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_stall,
  output logic              out_valid,
  input  logic              out_stall,
  output logic [DATA_W-1:0] out_data
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             full_w, pop_w, push_w;
  logic [IDX_W-1:0] rd_idx_w;

  assign pop_w  = out_valid & ~out_stall;
  // A write into a full queue is refused unless a read frees a slot on the same edge.
  assign push_w = in_valid & (~full_w | pop_w);

  sfq_shift_chain #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .shift_en (push_w),
    .din      (in_data),
    .rd_idx   (rd_idx_w),
    .dout     (out_data)
  );

  sfq_occupancy #(.DEPTH(DEPTH), .ROUND_TRIP(ROUND_TRIP)) u_occ (
    .clk       (clk),
    .rst       (rst),
    .wr        (push_w),
    .rd        (pop_w),
    .rd_idx    (rd_idx_w),
    .not_empty (out_valid),
    .full      (full_w),
    .stall     (in_stall)
  );

endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_stall,
  input logic              out_valid,
  input logic              out_stall,
  input logic [DATA_W-1:0] out_data,
  input logic              full
);

  logic pop;
  assign pop = out_valid & ~out_stall;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_stall));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (full && in_valid) |-> pop);

  assert_stall_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!in_stall && !in_valid) |=> !in_stall);

  assert_stall_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (in_stall && !pop) |=> in_stall);

  assert_swap_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pop) |=> (out_valid && $stable(in_stall)));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stall) |=> (out_valid && $stable(out_data)));

  assert_first_flit_R7: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && in_valid) |=> out_valid);

endmodule

bind sr_flit_queue sfq_checker #(.DATA_W(DATA_W)) u_sfq_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_stall  (in_stall),
  .out_valid (out_valid),
  .out_stall (out_stall),
  .out_data  (out_data),
  .full      (full_w)
);

// File: tb/tb_sr_flit_queue.sv
module tb_sr_flit_queue;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int D  = 16;
  localparam int RT = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_stall;
  logic         out_valid;
  logic         out_stall = 1'b0;
  logic [W-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_flit_queue #(.DATA_W(W), .DEPTH(D), .ROUND_TRIP(RT)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_stall(in_stall), .out_valid(out_valid), .out_stall(out_stall),
    .out_data(out_data)
  );

  int total = 0;
  int bad   = 0;
  logic [W-1:0] exp_q[$];
  logic [RT:0]  hist = '0;
  int           seq = 0;
  int           cnt_m = 0;
  int           pops = 0;
  logic         prev_hold = 1'b0;
  logic         prev_swap = 1'b0;
  logic         prev_stall = 1'b0;
  logic [W-1:0] prev_data = '0;

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver: one cycle, inputs change just after the rising edge.
  task automatic step(input logic send, input logic hold);
    logic [W-1:0] v;
    @(posedge clk);
    #1;
    hist      = {hist[RT-1:0], in_stall};
    out_stall = hold;
    if (send && !hist[RT]) begin
      v = {16'hC35A ^ seq[15:0], seq[15:0]};
      in_valid = 1'b1;
      in_data  = v;
      exp_q.push_back(v);
      seq++;
    end else begin
      in_valid = 1'b0;
    end
  endtask

  // Monitor: samples at the falling edge, then advances the model for the next edge.
  always @(negedge clk) begin
    if (!rst) begin
      logic pop, push;
      logic [W-1:0] e;
      check(in_stall == ((D - cnt_m) <= RT), "R4 stall threshold", W'(in_stall),
            W'((D - cnt_m) <= RT));
      check(out_valid == (cnt_m != 0), "R7 valid vs occupancy", W'(out_valid),
            W'(cnt_m != 0));
      if (prev_swap) begin
        check(out_valid && (in_stall == prev_stall), "R5 swap keeps occupancy",
              {30'b0, out_valid, in_stall}, {30'b0, 1'b1, prev_stall});
      end
      if (prev_hold && out_valid) begin
        check(out_data == prev_data, "R6 held data stable", out_data, prev_data);
      end
      pop  = out_valid && !out_stall;
      push = in_valid;
      if (push && cnt_m == D && !pop) begin
        check(1'b0, "R3 write into full queue", W'(cnt_m), W'(D - 1));
      end
      if (pop) begin
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
        check(out_data === e, "R2 order and content", out_data, e);
        pops++;
      end
      prev_hold  = out_valid && out_stall;
      prev_swap  = push && pop;
      prev_stall = in_stall;
      prev_data  = out_data;
      cnt_m = cnt_m + (push ? 1 : 0) - (pop ? 1 : 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", '0, '1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !in_stall, "R1 reset state", {30'b0, out_valid, in_stall}, '0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !in_stall, "R1 state after reset", {30'b0, out_valid, in_stall}, '0);

    // Single flit into an empty queue (R7, R2).
    step(1'b1, 1'b0);
    repeat (4) step(1'b0, 1'b0);

    // Continuous streaming: write and read together (R5).
    repeat (40) step(1'b1, 1'b0);

    // Fill with reads held and a late-reacting sender (R3, R6, R8).
    repeat (40) step(1'b1, 1'b1);
    @(negedge clk);
    check(in_stall && out_valid, "R4 stall at full", {30'b0, in_stall, out_valid}, 32'd3);
    pops = 0;
    repeat (25) step(1'b0, 1'b0);
    @(negedge clk);
    check(pops == D, "R8 exact fill to depth", W'(pops), W'(D));

    // Irregular traffic on both sides.
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, ($urandom % 3) == 0);
    end
    repeat (30) step(1'b0, 1'b0);
    @(negedge clk);
    check(exp_q.size() == 0, "R2 all flits delivered", W'(exp_q.size()), '0);
    finish_up();
  end

endmodule